// File: doc/BRIEF.md
# Load-Run-Drain Phase Sequencer

This block is the top-level sequencer for a pattern-engine test rig. The rig's program store and result store share one memory read port. Three clients use that port: a serial program loader, the pattern engine and a result drainer. The sequencer steps through three phases in a fixed cycle: accepting a program, running it, and draining the results. The current phase decides which client owns the read port, when the engine receives its start pulse, and whether bytes from the serial receiver reach the loader or are thrown away.

A host loads a program, and the loader reports completion. The engine then gets one start pulse and runs until it reports halt. The drainer then streams the result store out and reports when it has finished. Control then returns to program acceptance, so runs can follow one another with no reconfiguration. The completion and halt inputs are level signals. A halt flag still set from the previous run is ignored in the cycle the new start pulse is out.

The reset input is asynchronous and active-low. Its release is synchronized internally over two clock edges.

Top module: `lrd_sequencer`

## Requirements
- R1: While reset is active, and until its synchronized release, `phase_o` is 0, `eng_start` is 0, `rd_gnt` is all zero, `mem_rd_en` is 0 and `ld_rx_valid` is 0.
- R2: Phases advance only in the order accept (0), run (1), drain (2), then back to accept. The move happens on the clock edge that samples the advancing input of the current phase: `load_done` in accept, `eng_halted` in run, `drain_done` in drain. Advancing inputs that belong to other phases have no effect.
- R3: `eng_start` is high for exactly one cycle: the first cycle in which `phase_o` is 1. It is high at no other time.
- R4: `eng_halted` is ignored in the cycle in which `eng_start` is high. The phase stays at run for the following cycle.
- R5: The read port is owned by the loader in accept, by the engine in run and by the drainer in drain. `rd_gnt` bit 0 is the loader, bit 1 the engine and bit 2 the drainer. A grant bit is high only when its client requests and owns the port. `mem_rd_en` is high exactly when a grant is high, and `mem_rd_addr` then equals the owner's address.
- R6: `rd_gnt` has at most one bit set. Ownership changes in the same cycle as `phase_o`.
- R7: In accept, `ld_rx_valid` follows `rx_valid` and `ld_rx_data` carries `rx_data`. In run and drain, `ld_rx_valid` is 0 and every received byte is discarded: `rx_drop` equals `rx_valid`.
- R8: `phase_o` never takes the value 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_done | input | 1 | Loader has a complete program |
| eng_halted | input | 1 | Engine reports halt |
| drain_done | input | 1 | Drainer has sent the whole result store |
| eng_start | output | 1 | One-cycle engine start pulse |
| phase_o | output | 2 | Current phase: 0 accept, 1 run, 2 drain |
| ld_rd_req | input | 1 | Loader read request |
| ld_rd_addr | input | ADDR_W | Loader read address |
| eng_rd_req | input | 1 | Engine read request |
| eng_rd_addr | input | ADDR_W | Engine read address |
| drn_rd_req | input | 1 | Drainer read request |
| drn_rd_addr | input | ADDR_W | Drainer read address |
| rd_gnt | output | 3 | Read grant per client (bit 0 loader, 1 engine, 2 drainer) |
| mem_rd_en | output | 1 | Shared memory read enable |
| mem_rd_addr | output | ADDR_W | Shared memory read address |
| rx_valid | input | 1 | Serial receiver byte strobe |
| rx_data | input | BYTE_W | Serial receiver byte |
| ld_rx_valid | output | 1 | Byte strobe towards the loader |
| ld_rx_data | output | BYTE_W | Byte towards the loader |
| rx_drop | output | 1 | A received byte is being discarded |

## Verification
The hardest case to reach is an engine halt flag that is still set from the previous run when the next run begins. From the ports this looks exactly like a real halt in the start cycle. The stimulus recreates it by holding `eng_halted` high through the cycle that enters the run phase, then checking that the phase stays at run for a further cycle. Two more cases need deliberate stimulus. One is a reset that lands in the middle of a run while every client is requesting. The other is a sweep of every request and receive pattern in each phase, with the advancing inputs of the other phases toggled alongside.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
  typedef enum logic [1:0] {
    PH_ACCEPT = 2'd0,
    PH_RUN    = 2'd1,
    PH_DRAIN  = 2'd2
  } phase_e;

  localparam int unsigned N_CLIENTS  = 3;
  localparam int unsigned CL_LOADER  = 0;
  localparam int unsigned CL_ENGINE  = 1;
  localparam int unsigned CL_DRAINER = 2;
endpackage

// File: rtl/lrd_rst_sync.sv
module lrd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];
endmodule

// File: rtl/lrd_phase_fsm.sv
module lrd_phase_fsm
  import lrd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_done,
  input  logic   eng_halted,
  input  logic   drain_done,
  output phase_e phase_q,
  output logic   start_q
);
  phase_e phase_d;
  logic   enter_run;
  logic   phase_en;
  logic   start_en;

  // next-state process
  always_comb begin
    phase_d   = phase_q;
    enter_run = 1'b0;
    unique case (phase_q)
      PH_ACCEPT: if (load_done) begin
        phase_d   = PH_RUN;
        enter_run = 1'b1;
      end
      // a halt still set from the prior run is blanked while start is out
      PH_RUN:    if (eng_halted && !start_q) phase_d = PH_DRAIN;
      PH_DRAIN:  if (drain_done) phase_d = PH_ACCEPT;
      default:   phase_d = PH_ACCEPT;
    endcase
  end

  assign phase_en = (phase_d != phase_q);
  assign start_en = enter_run | start_q;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ACCEPT;
      start_q <= 1'b0;
    end else begin
      if (phase_en) phase_q <= phase_d;
      if (start_en) start_q <= enter_run;
    end
  end
endmodule

// File: rtl/lrd_port_mux.sv
module lrd_port_mux #(
  parameter int unsigned N_CL   = 3,
  parameter int unsigned ADDR_W = 10
) (
  input  logic                     active,
  input  logic [N_CL-1:0]          owner,
  input  logic [N_CL-1:0]          req,
  input  logic [N_CL*ADDR_W-1:0]   addr_flat,
  output logic [N_CL-1:0]          gnt,
  output logic                     mem_rd_en,
  output logic [ADDR_W-1:0]        mem_rd_addr
);
  for (genvar i = 0; i < N_CL; i++) begin : g_gnt
    assign gnt[i] = active & owner[i] & req[i];
  end

  always_comb begin
    mem_rd_addr = '0;
    for (int i = 0; i < N_CL; i++) begin
      mem_rd_addr = mem_rd_addr |
                    (addr_flat[i*ADDR_W +: ADDR_W] & {ADDR_W{owner[i]}});
    end
  end

  assign mem_rd_en = |gnt;
endmodule

// File: rtl/lrd_rx_gate.sv
module lrd_rx_gate #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              active,
  input  logic              accepting,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              ld_rx_valid,
  output logic [BYTE_W-1:0] ld_rx_data,
  output logic              rx_drop
);
  logic to_loader;

  assign to_loader   = active & accepting;
  assign ld_rx_valid = rx_valid & to_loader;
  assign ld_rx_data  = rx_data;
  assign rx_drop     = rx_valid & ~to_loader;
endmodule

// File: rtl/lrd_sequencer.sv
module lrd_sequencer
  import lrd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 10,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_done,
  input  logic              eng_halted,
  input  logic              drain_done,
  output logic              eng_start,
  output logic [1:0]        phase_o,
  input  logic              ld_rd_req,
  input  logic [ADDR_W-1:0] ld_rd_addr,
  input  logic              eng_rd_req,
  input  logic [ADDR_W-1:0] eng_rd_addr,
  input  logic              drn_rd_req,
  input  logic [ADDR_W-1:0] drn_rd_addr,
  output logic [2:0]        rd_gnt,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              ld_rx_valid,
  output logic [BYTE_W-1:0] ld_rx_data,
  output logic              rx_drop
);
  localparam int unsigned FLAT_W = N_CLIENTS * ADDR_W;

  logic                 rst_n_s;
  phase_e               phase_q;
  logic [N_CLIENTS-1:0] owner;
  logic [N_CLIENTS-1:0] req;
  logic [FLAT_W-1:0]    addr_flat;

  lrd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  lrd_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_done  (load_done),
    .eng_halted (eng_halted),
    .drain_done (drain_done),
    .phase_q    (phase_q),
    .start_q    (eng_start)
  );

  // phase code doubles as the owning client index
  for (genvar i = 0; i < N_CLIENTS; i++) begin : g_own
    assign owner[i] = (phase_q == phase_e'(i));
  end

  assign req[CL_LOADER]  = ld_rd_req;
  assign req[CL_ENGINE]  = eng_rd_req;
  assign req[CL_DRAINER] = drn_rd_req;
  assign addr_flat[CL_LOADER*ADDR_W  +: ADDR_W] = ld_rd_addr;
  assign addr_flat[CL_ENGINE*ADDR_W  +: ADDR_W] = eng_rd_addr;
  assign addr_flat[CL_DRAINER*ADDR_W +: ADDR_W] = drn_rd_addr;

  lrd_port_mux #(.N_CL(N_CLIENTS), .ADDR_W(ADDR_W)) u_mux (
    .active      (rst_n_s),
    .owner       (owner),
    .req         (req),
    .addr_flat   (addr_flat),
    .gnt         (rd_gnt),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr)
  );

  lrd_rx_gate #(.BYTE_W(BYTE_W)) u_rx (
    .active      (rst_n_s),
    .accepting   (owner[CL_LOADER]),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .ld_rx_valid (ld_rx_valid),
    .ld_rx_data  (ld_rx_data),
    .rx_drop     (rx_drop)
  );

  assign phase_o = phase_q;
endmodule

// File: rtl/lrd_sequencer_chk.sv
module lrd_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_start,
  input logic [1:0] phase_o,
  input logic       ld_rd_req,
  input logic       eng_rd_req,
  input logic       drn_rd_req,
  input logic [2:0] rd_gnt,
  input logic       mem_rd_en,
  input logic       rx_valid,
  input logic       ld_rx_valid,
  input logic       rx_drop
);
  p_order_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0) |=> (phase_o == 2'd0 || phase_o == 2'd1));
  p_order_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1) |=> (phase_o == 2'd1 || phase_o == 2'd2));
  p_order_drn_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd2) |=> (phase_o == 2'd2 || phase_o == 2'd0));
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_start_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (phase_o == 2'd1 && $past(phase_o) != 2'd1));
  p_entry_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd1 && $past(phase_o) != 2'd1) |-> eng_start);
  p_stale_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> (phase_o == 2'd1));
  p_gnt_ld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt[0] |-> (phase_o == 2'd0 && ld_rd_req));
  p_gnt_eng_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt[1] |-> (phase_o == 2'd1 && eng_rd_req));
  p_gnt_drn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gnt[2] |-> (phase_o == 2'd2 && drn_rd_req));
  p_en_gnt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (rd_gnt != 3'b000));
  p_gnt_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_gnt));
  p_rx_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rx_valid |-> (phase_o == 2'd0 && rx_valid && !rx_drop));
  p_rx_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && phase_o != 2'd0) |-> rx_drop);
  p_phase_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_o != 2'd3);
endmodule

bind lrd_sequencer lrd_sequencer_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eng_start   (eng_start),
  .phase_o     (phase_o),
  .ld_rd_req   (ld_rd_req),
  .eng_rd_req  (eng_rd_req),
  .drn_rd_req  (drn_rd_req),
  .rd_gnt      (rd_gnt),
  .mem_rd_en   (mem_rd_en),
  .rx_valid    (rx_valid),
  .ld_rx_valid (ld_rx_valid),
  .rx_drop     (rx_drop)
);

// File: tb/tb_lrd_sequencer.sv
module tb_lrd_sequencer;
  localparam int ADDR_W = 10;
  localparam int BYTE_W = 8;
  localparam int ROUNDS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_done = 1'b0, eng_halted = 1'b0, drain_done = 1'b0;
  logic eng_start;
  logic [1:0] phase_o;
  logic ld_rd_req = 1'b0, eng_rd_req = 1'b0, drn_rd_req = 1'b0;
  logic [ADDR_W-1:0] ld_rd_addr = '0, eng_rd_addr = '0, drn_rd_addr = '0;
  logic [2:0] rd_gnt;
  logic mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic rx_valid = 1'b0;
  logic [BYTE_W-1:0] rx_data = '0;
  logic ld_rx_valid;
  logic [BYTE_W-1:0] ld_rx_data;
  logic rx_drop;

  int n_chk = 0;
  int n_fail = 0;
  int mph = 0;
  bit mstart = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lrd_sequencer #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk, n_fail);
  endtask

  // drive just after a falling edge, check combinational outputs,
  // then check registered outputs after the next falling edge
  task automatic step(input logic ld, input logic hal, input logic dd,
                      input int pat, input int salt);
    int nxt;
    int eg;
    int ea;
    load_done   = ld;
    eng_halted  = hal;
    drain_done  = dd;
    ld_rd_req   = pat[0];
    eng_rd_req  = pat[1];
    drn_rd_req  = pat[2];
    rx_valid    = pat[3];
    ld_rd_addr  = ADDR_W'(pat * 7 + salt);
    eng_rd_addr = ADDR_W'(pat * 11 + salt + 300);
    drn_rd_addr = ADDR_W'(pat * 13 + salt + 600);
    rx_data     = BYTE_W'(pat * 17 + salt);
    #1;
    eg = 0;
    if (mph == 0 && pat[0]) eg = 1;
    if (mph == 1 && pat[1]) eg = 2;
    if (mph == 2 && pat[2]) eg = 4;
    ea = (mph == 0) ? int'(ld_rd_addr) :
         (mph == 1) ? int'(eng_rd_addr) : int'(drn_rd_addr);
    chk(rd_gnt == 3'(eg), "R5", "rd_gnt", int'(rd_gnt), eg);
    chk(mem_rd_en == (eg != 0), "R5", "mem_rd_en", int'(mem_rd_en),
        int'(eg != 0));
    if (eg != 0)
      chk(int'(mem_rd_addr) == ea, "R5", "mem_rd_addr",
          int'(mem_rd_addr), ea);
    chk(ld_rx_valid == (pat[3] && mph == 0), "R7", "ld_rx_valid",
        int'(ld_rx_valid), int'(pat[3] && mph == 0));
    chk(rx_drop == (pat[3] && mph != 0), "R7", "rx_drop",
        int'(rx_drop), int'(pat[3] && mph != 0));
    if (mph == 0 && pat[3])
      chk(ld_rx_data == rx_data, "R7", "ld_rx_data",
          int'(ld_rx_data), int'(rx_data));
    nxt = mph;
    if (mph == 0 && ld) nxt = 1;
    if (mph == 1 && hal && !mstart) nxt = 2;
    if (mph == 2 && dd) nxt = 0;
    @(negedge clk);
    mstart = (mph != 1 && nxt == 1);
    mph = nxt;
    chk(int'(phase_o) == mph, "R2", "phase_o", int'(phase_o), mph);
    chk(eng_start == mstart, "R3", "eng_start", int'(eng_start),
        int'(mstart));
    chk(phase_o != 2'd3, "R8", "phase_o legal", int'(phase_o), 0);
  endtask

  task automatic idle_release();
    load_done = 0; eng_halted = 0; drain_done = 0;
    ld_rd_req = 1; eng_rd_req = 1; drn_rd_req = 1; rx_valid = 1;
    @(negedge clk);
    rst_n = 1'b1;
    // synchronized release takes two rising edges
    @(negedge clk);
    #1;
    chk(rd_gnt == 3'b000, "R1", "rd_gnt in sync release", int'(rd_gnt), 0);
    chk(ld_rx_valid == 1'b0, "R1", "ld_rx_valid in sync release",
        int'(ld_rx_valid), 0);
    @(negedge clk);
    @(negedge clk);
    mph = 0;
    mstart = 0;
  endtask

  task automatic check_reset_state();
    #1;
    chk(phase_o == 2'd0, "R1", "phase_o in reset", int'(phase_o), 0);
    chk(eng_start == 1'b0, "R1", "eng_start in reset", int'(eng_start), 0);
    chk(rd_gnt == 3'b000, "R1", "rd_gnt in reset", int'(rd_gnt), 0);
    chk(mem_rd_en == 1'b0, "R1", "mem_rd_en in reset", int'(mem_rd_en), 0);
    chk(ld_rx_valid == 1'b0, "R1", "ld_rx_valid in reset",
        int'(ld_rx_valid), 0);
  endtask

  task automatic round(input int r);
    // accept: halt and drain-done must not move the phase (R2)
    for (int p = 0; p < 16; p++) step(0, p[0], p[1], p, r);
    step(1, 1, 0, r % 16, r);
    // run entry with halt still high from the prior run (R4)
    step(0, 1, 1, 15, r);
    chk(mph == 1, "R4", "phase after stale halt", int'(phase_o), 1);
    for (int p = 0; p < 16; p++) step(p[0], 0, p[1], p, r + 1);
    step(0, 1, 0, (r + 5) % 16, r);
    // drain: load-done and halt must not move the phase (R2)
    for (int p = 0; p < 16; p++) step(p[0], p[1], 0, p, r + 2);
    step(0, 0, 1, (r + 9) % 16, r);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual 0 expected 1");
      report();
      $finish;
    end
  end

  initial begin
    ld_rd_req = 1; eng_rd_req = 1; drn_rd_req = 1; rx_valid = 1;
    load_done = 1;
    repeat (3) @(negedge clk);
    check_reset_state();
    idle_release();
    for (int r = 0; r < ROUNDS; r++) round(r);
    // reset in the middle of a run with every client requesting (R1)
    step(1, 0, 0, 15, 40);
    step(0, 0, 0, 15, 40);
    rst_n = 1'b0;
    ld_rd_req = 1; eng_rd_req = 1; drn_rd_req = 1; rx_valid = 1;
    check_reset_state();
    idle_release();
    round(7);
    done = 1;
    report();
    $finish;
  end
endmodule